// File: doc/BRIEF.md
# T1 Frame Multiplexer with D4 Superframe Framing

This block turns 24 parallel 8-bit voice channels into one serial T1 bit stream. Each pulse of the bit-enable strobe moves the stream forward by one bit. Every frame is 193 bits long. It opens with one framing bit, and then the 24 time slots follow in channel order, one byte each. Frames are counted in groups of twelve. The framing bit of each frame follows the fixed twelve-frame D4 sequence, so a receiver can find both frame and superframe alignment.

At the point where the framing bit is left, the block captures all channel bytes, the two signaling vectors and the robbed-bit enable in one step. A frame is therefore built from one consistent snapshot. When robbed-bit signaling is on for a frame, the least-significant bit of every slot in frames 6 and 12 carries that channel's signaling bit in place of data.

The block drives these outputs:
- the serial bit;
- a frame-start level that covers the framing-bit position;
- a superframe-start level that covers the framing bit of frame 1;
- the current slot index.

Top module: `t1_frame_mux`

## Requirements
- R1: A synchronous active-high reset places the output at frame 1, framing-bit position. In that state ser_out=1, frame_start=1, sf_start=1 and slot_idx=0.
- R2: A frame has 193 bit positions. slot_idx is 0 during the framing bit. It is k (1..24) during the 8 positions of slot k. After the last bit of slot 24 the output returns to slot_idx 0.
- R3: The framing bit of frames 1 to 12 of each superframe follows the sequence 1,0,0,0,1,1,0,1,1,1,0,0, and the sequence then repeats.
- R4: Slot k carries channel k's byte, taken from ch_data[8k-1:8k-8]. The byte is sent most-significant bit first.
- R5: ch_data, sig_a, sig_b and rob_en are sampled once, on the bit_en edge that ends the framing bit. Changes to them later in the same frame have no effect on that frame.
- R6: When the sampled rob_en is 1, the last bit (LSB) of slot k is replaced. In frame 6 it carries sig_a[k-1], and in frame 12 it carries sig_b[k-1]. All other frames are unaffected.
- R7: When the sampled rob_en is 0, frames 6 and 12 carry data in every bit, and sig_a and sig_b have no effect.
- R8: frame_start is 1 exactly during framing-bit positions. sf_start is 1 exactly during the framing bit of frame 1.
- R9: While bit_en is 0, ser_out, slot_idx, frame_start and sf_start hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Advance the stream by one bit on this clock |
| rob_en | input | 1 | Robbed-bit signaling enable, sampled per frame |
| ch_data | input | 192 | 24 channel bytes, channel k at bits 8k-1:8k-8 |
| sig_a | input | 24 | Signaling bit A per channel (frame 6) |
| sig_b | input | 24 | Signaling bit B per channel (frame 12) |
| ser_out | output | 1 | Serial T1 bit for the current position |
| frame_start | output | 1 | High during the framing-bit position |
| sf_start | output | 1 | High during the framing bit of frame 1 |
| slot_idx | output | 5 | 0 for the framing bit, 1..24 for the time slots |

## Verification
All outputs are decoded combinationally from registered position and snapshot state. Each result is therefore due in the first cycle after the bit_en edge that moves the position, and it stays valid until the next enabled edge.

The bench drives inputs at the falling edge. At the next falling edge it first advances its own position model, but only if the previous drive had bit_en set. It then compares all four outputs, so every check falls half a period after the register update that produced it. The input snapshot counts as taken on the enabled edge that leaves position 0. The bench corrupts the inputs four bits later, so a late capture shows up as a data mismatch.

// File: rtl/t1_mux_pkg.sv
package t1_mux_pkg;

  localparam int unsigned SF_LEN = 12;
  localparam int unsigned FRAME_W = 4;

  // bit i is the framing bit of frame i+1
  localparam logic [SF_LEN-1:0] SF_PATTERN = 12'b0011_1011_0001;

  typedef enum logic [1:0] {
    SIG_NONE = 2'd0,
    SIG_A    = 2'd1,
    SIG_B    = 2'd2
  } sig_kind_e;

  function automatic logic sf_fbit(input logic [FRAME_W-1:0] fidx);
    return SF_PATTERN[fidx];
  endfunction

  function automatic sig_kind_e sig_kind(input logic [FRAME_W-1:0] fidx);
    if (fidx == FRAME_W'(5))  return SIG_A;
    if (fidx == FRAME_W'(11)) return SIG_B;
    return SIG_NONE;
  endfunction

  function automatic logic [FRAME_W-1:0] next_frame(input logic [FRAME_W-1:0] fidx);
    return (fidx == FRAME_W'(SF_LEN - 1)) ? '0 : fidx + FRAME_W'(1);
  endfunction

endpackage

// File: rtl/t1_pos_counter.sv
module t1_pos_counter #(
  parameter int NUM_CH  = 24,
  parameter int CH_BITS = 8,
  localparam int SLOT_W = $clog2(NUM_CH + 1),
  localparam int BIT_W  = (CH_BITS > 1) ? $clog2(CH_BITS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  output logic [SLOT_W-1:0]             slot,
  output logic [BIT_W-1:0]              bitn,
  output logic [t1_mux_pkg::FRAME_W-1:0] frame,
  output logic                          at_fbit,
  output logic                          frame_last,
  output logic                          sf_last
);
  import t1_mux_pkg::*;

  logic [SLOT_W-1:0]  slot_q;
  logic [BIT_W-1:0]   bit_q;
  logic [FRAME_W-1:0] frame_q;
  logic               slot_end;

  assign slot_end   = (bit_q == BIT_W'(CH_BITS - 1));
  assign at_fbit    = (slot_q == '0);
  assign frame_last = slot_end && (slot_q == SLOT_W'(NUM_CH));
  assign sf_last    = frame_last && (frame_q == FRAME_W'(SF_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= '0;
      bit_q   <= '0;
      frame_q <= '0;
    end else if (en) begin
      if (at_fbit) begin
        slot_q <= SLOT_W'(1);
        bit_q  <= '0;
      end else if (slot_end) begin
        bit_q <= '0;
        if (frame_last) begin
          slot_q  <= '0;
          frame_q <= next_frame(frame_q);
        end else begin
          slot_q <= slot_q + SLOT_W'(1);
        end
      end else begin
        bit_q <= bit_q + BIT_W'(1);
      end
    end
  end

  assign slot  = slot_q;
  assign bitn  = bit_q;
  assign frame = frame_q;
endmodule

// File: rtl/t1_frame_store.sv
module t1_frame_store #(
  parameter int NUM_CH  = 24,
  parameter int CH_BITS = 8,
  localparam int DATA_W = NUM_CH * CH_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  input  logic [NUM_CH-1:0] siga_in,
  input  logic [NUM_CH-1:0] sigb_in,
  input  logic              rob_in,
  output logic [DATA_W-1:0] data_q,
  output logic [NUM_CH-1:0] siga_q,
  output logic [NUM_CH-1:0] sigb_q,
  output logic              rob_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      siga_q <= '0;
      sigb_q <= '0;
      rob_q  <= 1'b0;
    end else if (load) begin
      data_q <= data_in;
      siga_q <= siga_in;
      sigb_q <= sigb_in;
      rob_q  <= rob_in;
    end
  end
endmodule

// File: rtl/t1_bit_select.sv
module t1_bit_select #(
  parameter int NUM_CH  = 24,
  parameter int CH_BITS = 8,
  localparam int DATA_W = NUM_CH * CH_BITS,
  localparam int SLOT_W = $clog2(NUM_CH + 1),
  localparam int BIT_W  = (CH_BITS > 1) ? $clog2(CH_BITS) : 1
) (
  input  logic [DATA_W-1:0]              data_q,
  input  logic [NUM_CH-1:0]              siga_q,
  input  logic [NUM_CH-1:0]              sigb_q,
  input  logic                           rob_q,
  input  logic [SLOT_W-1:0]              slot,
  input  logic [BIT_W-1:0]               bitn,
  input  logic [t1_mux_pkg::FRAME_W-1:0] frame,
  output logic                           ser
);
  import t1_mux_pkg::*;

  logic [CH_BITS-1:0] slot_bytes [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    assign slot_bytes[g] = data_q[g*CH_BITS +: CH_BITS];
  end

  logic [SLOT_W-1:0]  ch_idx;
  logic [CH_BITS-1:0] cur_byte;
  logic               is_lsb;
  sig_kind_e          kind;

  assign ch_idx = slot - SLOT_W'(1);
  assign is_lsb = (bitn == BIT_W'(CH_BITS - 1));
  assign kind   = sig_kind(frame);

  always_comb begin
    cur_byte = '0;
    ser      = 1'b0;
    if (slot == '0) begin
      ser = sf_fbit(frame);
    end else begin
      cur_byte = slot_bytes[ch_idx];
      ser      = cur_byte[BIT_W'(CH_BITS - 1) - bitn];
      if (rob_q && is_lsb) begin
        if (kind == SIG_A) ser = siga_q[ch_idx];
        else if (kind == SIG_B) ser = sigb_q[ch_idx];
      end
    end
  end
endmodule

// File: rtl/t1_frame_mux.sv
module t1_frame_mux #(
  parameter int NUM_CH  = 24,
  parameter int CH_BITS = 8,
  localparam int DATA_W = NUM_CH * CH_BITS,
  localparam int SLOT_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              rob_en,
  input  logic [DATA_W-1:0] ch_data,
  input  logic [NUM_CH-1:0] sig_a,
  input  logic [NUM_CH-1:0] sig_b,
  output logic              ser_out,
  output logic              frame_start,
  output logic              sf_start,
  output logic [SLOT_W-1:0] slot_idx
);
  import t1_mux_pkg::*;

  localparam int BIT_W = (CH_BITS > 1) ? $clog2(CH_BITS) : 1;

  logic [SLOT_W-1:0]  slot;
  logic [BIT_W-1:0]   bitn;
  logic [FRAME_W-1:0] frame;
  logic               at_fbit;
  logic               frame_last;
  logic               sf_last;
  logic               snap_load;

  logic [DATA_W-1:0]  data_q;
  logic [NUM_CH-1:0]  siga_q;
  logic [NUM_CH-1:0]  sigb_q;
  logic               rob_q;

  t1_pos_counter #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS)) u_pos (
    .clk(clk), .rst(rst), .en(bit_en),
    .slot(slot), .bitn(bitn), .frame(frame),
    .at_fbit(at_fbit), .frame_last(frame_last), .sf_last(sf_last)
  );

  assign snap_load = bit_en && at_fbit;

  t1_frame_store #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS)) u_store (
    .clk(clk), .rst(rst), .load(snap_load),
    .data_in(ch_data), .siga_in(sig_a), .sigb_in(sig_b), .rob_in(rob_en),
    .data_q(data_q), .siga_q(siga_q), .sigb_q(sigb_q), .rob_q(rob_q)
  );

  t1_bit_select #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS)) u_sel (
    .data_q(data_q), .siga_q(siga_q), .sigb_q(sigb_q), .rob_q(rob_q),
    .slot(slot), .bitn(bitn), .frame(frame), .ser(ser_out)
  );

  assign frame_start = at_fbit;
  assign sf_start    = at_fbit && (frame == '0);
  assign slot_idx    = slot;
endmodule

// File: rtl/t1_frame_mux_chk.sv
module t1_frame_mux_chk #(
  parameter int NUM_CH = 24,
  localparam int SLOT_W = $clog2(NUM_CH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_en,
  input logic              ser_out,
  input logic              frame_start,
  input logic              sf_start,
  input logic [SLOT_W-1:0] slot_idx,
  input logic              frame_last,
  input logic              sf_last
);
  a_r2_wrap_to_fbit: assert property (@(posedge clk) disable iff (rst)
    bit_en && frame_last |=> frame_start);

  a_r2_fbit_to_slot1: assert property (@(posedge clk) disable iff (rst)
    bit_en && frame_start |=> slot_idx == SLOT_W'(1));

  a_r3_frame1_fbit_one: assert property (@(posedge clk) disable iff (rst)
    sf_start |-> ser_out);

  a_r8_sf_wrap: assert property (@(posedge clk) disable iff (rst)
    bit_en && sf_last |=> sf_start);

  a_r8_sf_inside_frame: assert property (@(posedge clk) disable iff (rst)
    sf_start |-> frame_start);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(slot_idx) && $stable(ser_out) && $stable(frame_start) && $stable(sf_start));
endmodule

bind t1_frame_mux t1_frame_mux_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .ser_out(ser_out),
  .frame_start(frame_start), .sf_start(sf_start), .slot_idx(slot_idx),
  .frame_last(frame_last), .sf_last(sf_last)
);

// File: tb/test_t1_frame_mux.sv
module test_t1_frame_mux;
  localparam int PERIOD = 10;
  localparam int NV = 4;
  localparam logic [7:0]  V_SEED [NV] = '{8'h5A, 8'h00, 8'hC3, 8'h17};
  localparam logic        V_ROB  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic        V_GAP  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [23:0] V_SIGA [NV] = '{24'hA5F00F, 24'hFFFFFF, 24'h123456, 24'h0F0F0F};
  localparam logic [23:0] V_SIGB [NV] = '{24'h3C3C3C, 24'hFFFFFF, 24'hFEDCBA, 24'hF0F0F0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic rob_en = 1'b0;
  logic [191:0] ch_data = '0;
  logic [23:0] sig_a = '0, sig_b = '0;
  logic ser_out, frame_start, sf_start;
  logic [4:0] slot_idx;

  int checks = 0, fails = 0, cyc = 0;
  int pos = 0, gf = 0;
  logic en_prev = 1'b0;
  logic [191:0] e_data = '0;
  logic [23:0] e_siga = '0, e_sigb = '0;
  logic e_rob = 1'b0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  t1_frame_mux i_t1_frame_mux (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rob_en(rob_en), .ch_data(ch_data),
    .sig_a(sig_a), .sig_b(sig_b), .ser_out(ser_out), .frame_start(frame_start),
    .sf_start(sf_start), .slot_idx(slot_idx)
  );

  function automatic logic fpat(input int f);
    // frames 1,5,6,8,9,10 carry a 1 (index is frame-1)
    return (f == 0) || (f == 4) || (f == 5) || (f == 7) || (f == 8) || (f == 9);
  endfunction

  function automatic logic [191:0] frame_vec(input logic [7:0] seed, input int f);
    logic [191:0] v;
    for (int c = 0; c < 24; c++)
      v[c*8 +: 8] = 8'((seed * 7) ^ (c * 29) ^ (f * 53) ^ (c << 3));
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s pos=%0d frame=%0d actual=%0d expected=%0d", tag, pos, gf % 12 + 1, act, exp);
    end
  endtask

  task automatic check_all();
    int s, b, f;
    logic eb;
    string tag;
    f = gf % 12;
    if (pos == 0) begin
      eb = fpat(f); tag = "R3";
    end else begin
      s = (pos - 1) / 8; b = (pos - 1) % 8;
      eb = e_data[s*8 + 7 - b]; tag = "R4 R5";
      if (b == 7 && (f == 5 || f == 11)) begin
        tag = e_rob ? "R6" : "R7";
        if (e_rob) eb = (f == 5) ? e_siga[s] : e_sigb[s];
      end
    end
    check(tag, ser_out, eb);
    check("R2 slot_idx", slot_idx, (pos == 0) ? 0 : (pos - 1) / 8 + 1);
    check("R8 frame_start", frame_start, pos == 0);
    check("R8 sf_start", sf_start, (pos == 0) && (f == 0));
  endtask

  task automatic step();
    int v;
    logic moved;
    @(negedge clk);
    cyc++;
    moved = en_prev;
    if (en_prev) begin
      pos++;
      if (pos == 193) begin pos = 0; gf++; end
    end
    check_all();
    v = (gf / 12) % NV;
    if (pos == 0) begin
      ch_data = frame_vec(V_SEED[v], gf);
      sig_a = V_SIGA[v]; sig_b = V_SIGB[v]; rob_en = V_ROB[v];
      e_data = ch_data; e_siga = sig_a; e_sigb = sig_b; e_rob = rob_en;
    end else if (pos == 4 && moved) begin
      ch_data = ~ch_data; sig_a = ~sig_a; sig_b = ~sig_b; rob_en = ~rob_en;
    end
    bit_en = V_GAP[v] ? (cyc % 3 != 2) : 1'b1;
    en_prev = bit_en;
  endtask

  task automatic reset_model();
    pos = 0; gf = 0; en_prev = 1'b0;
  endtask

  initial begin : watchdog
    #(PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic s_ser, s_fs, s_sf;
    logic [4:0] s_slot;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 ser_out", ser_out, 1);
    check("R1 frame_start", frame_start, 1);
    check("R1 sf_start", sf_start, 1);
    check("R1 slot_idx", slot_idx, 0);
    reset_model();
    // table walk: four vectors, one superframe each
    while (gf < 12 * NV) step();
    // R9 directed hold mid-frame
    while (pos != 50) step();
    bit_en = 1'b0; en_prev = 1'b0;
    @(negedge clk);
    s_ser = ser_out; s_fs = frame_start; s_sf = sf_start; s_slot = slot_idx;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R9 ser_out hold", ser_out, s_ser);
      check("R9 slot_idx hold", slot_idx, s_slot);
      check("R9 frame_start hold", frame_start, s_fs);
      check("R9 sf_start hold", sf_start, s_sf);
    end
    // R1 reset in the middle of a frame
    rst = 1'b1; bit_en = 1'b1;
    @(negedge clk);
    rst = 1'b0; bit_en = 1'b0;
    check("R1 mid ser_out", ser_out, 1);
    check("R1 mid frame_start", frame_start, 1);
    check("R1 mid sf_start", sf_start, 1);
    check("R1 mid slot_idx", slot_idx, 0);
    reset_model();
    // continue into frame 3 (framing bits 1,0,0)
    while (gf < 3) step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule